// File: doc/BRIEF.md
# JTAG Debug Transport with Register-Bus Access

This block is a JTAG test access port whose data registers carry accesses to a debug register bus. TCK clocks a 16-state TAP controller that is steered by TMS. TDI shifts into either the 5-bit instruction register or the data register that the instruction selects, and TDO returns the bits that shift out. There are four data registers: a one-bit bypass, a 32-bit identification word, a 32-bit transport control word, and a bus-access word of `ABITS+34` bits that holds an address, 32 data bits and a 2-bit operation.

A debugger selects the bus-access instruction and then scans a word in. When the TAP passes through Update-DR, a read or write request goes to the debug register port for exactly one TCK cycle. The port answers in the same cycle with read data and an accept flag. The block stores the outcome as a response word. The next scan of the same register returns that response, with a status code in the operation field. The control word reports the address width, an idle-cycle hint and the latest status. Scanning a control word with bit 16 set clears the stored response.

Top module: `dbg_jtag_xport`

## Requirements
- R1: The TAP follows the 16-state table. Asynchronous reset (`trst_n` low) puts it in Test-Logic-Reset. Five TCK cycles with TMS=1 reach Test-Logic-Reset from any state, and that state loads the IDCODE instruction. Update-DR and Update-IR go to Run-Test/Idle on TMS=0.
- R2: The instruction register is 5 bits wide and resets to IDCODE (5'h01). Capture-IR loads 5'b00001. The codes are 5'h10 for control, 5'h11 for bus access and 5'h1F for bypass.
- R3: During Shift-IR and Shift-DR the register shifts right by one bit per cycle. TDI enters at bit length−1 and bit 0 goes out on TDO. TDO is updated on the falling edge of TCK and is 0 in every state that does not shift.
- R4: With IDCODE selected, a 32-bit scan returns the `IDCODE_VAL` parameter, LSB first.
- R5: Bypass, and every instruction code not listed in R2, selects a 1-bit register that captures 0. TDO therefore repeats TDI one cycle later.
- R6: The control word reads version 1 in bits 3:0, `ABITS` in bits 9:4, the current response status in bits 11:10, `IDLE_HINT` in bits 14:12, and 0 in every other bit.
- R7: The bus-access word has length `ABITS+34`. The op/status field is bits 1:0, data is bits 33:2, and the address is bits `ABITS+33`:34.
- R8: In Update-DR with op=1 (read), `dbus_req` is high for exactly one cycle with `dbus_we`=0. If the port accepts, the response takes the read data, the request address and status 0.
- R9: In Update-DR with op=2 (write), the request carries `dbus_we`=1, the address and the data. If the port accepts, the status becomes 0 and the response data field keeps its old value.
- R10: When the port refuses a request (`dbus_ok`=0), the status becomes 2. The address is recorded and the data field keeps its old value.
- R11: Op=0 (no operation) and op=3 (reserved) issue no request and leave the response unchanged.
- R12: An Update-DR of the control word with bit 16 set clears the response: address, data and status all become 0.
- R13: After reset the response reads status 0 with zero address and data, and TDO and `dbus_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on TCK falling edge |
| dbus_req | output | 1 | One-cycle debug register request |
| dbus_we | output | 1 | 1 = write, 0 = read |
| dbus_addr | output | ABITS | Register address |
| dbus_wdata | output | 32 | Write data |
| dbus_rdata | input | 32 | Read data, valid in the request cycle |
| dbus_ok | input | 1 | Port accepts the request (same cycle) |

## Verification
A wrong TAP state shows up within a scan or two. The identification word comes back shifted or corrupted, or `dbus_req` rises on an unexpected cycle, and the scoreboard reports a request it did not expect. A corrupt response register appears on the very next bus-access scan, because that scan returns the whole stored response. Its address, data and status are compared bit by bit against a model of the requirements. A status error that would otherwise stay hidden also appears in the control word, so every control scan checks it as well.

// File: rtl/dbg_jtag_pkg.sv
package dbg_jtag_pkg;

    typedef enum logic [3:0] {
        TS_RESET  = 4'd0,
        TS_IDLE   = 4'd1,
        TS_SEL_DR = 4'd2,
        TS_CAP_DR = 4'd3,
        TS_SH_DR  = 4'd4,
        TS_EX1_DR = 4'd5,
        TS_PAU_DR = 4'd6,
        TS_EX2_DR = 4'd7,
        TS_UPD_DR = 4'd8,
        TS_SEL_IR = 4'd9,
        TS_CAP_IR = 4'd10,
        TS_SH_IR  = 4'd11,
        TS_EX1_IR = 4'd12,
        TS_PAU_IR = 4'd13,
        TS_EX2_IR = 4'd14,
        TS_UPD_IR = 4'd15
    } tap_state_e;

    localparam int          IR_W       = 5;
    localparam logic [4:0]  IRC_IDCODE = 5'h01;
    localparam logic [4:0]  IRC_CTRL   = 5'h10;
    localparam logic [4:0]  IRC_ACCESS = 5'h11;
    localparam logic [4:0]  IRC_BYPASS = 5'h1F;
    localparam logic [4:0]  IR_CAPTURE = 5'b00001;

    localparam logic [1:0]  OP_NOP = 2'd0;
    localparam logic [1:0]  OP_RD  = 2'd1;
    localparam logic [1:0]  OP_WR  = 2'd2;
    localparam logic [1:0]  OP_RSV = 2'd3;

    localparam logic [1:0]  ST_OK   = 2'd0;
    localparam logic [1:0]  ST_FAIL = 2'd2;

    localparam int          CTRL_CLR_BIT = 16;

endpackage

// File: rtl/dbg_tap_ctrl.sv
module dbg_tap_ctrl
    import dbg_jtag_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_o
);

    typedef struct packed {
        tap_state_e st;
    } tap_regs_t;

    tap_regs_t tap_d, tap_q;

    always_comb begin
        tap_d = tap_q;
        case (tap_q.st)
            TS_RESET:  tap_d.st = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   tap_d.st = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: tap_d.st = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: tap_d.st = tms ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:  tap_d.st = tms ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR: tap_d.st = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: tap_d.st = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: tap_d.st = tms ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR: tap_d.st = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: tap_d.st = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: tap_d.st = tms ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:  tap_d.st = tms ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR: tap_d.st = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: tap_d.st = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: tap_d.st = tms ? TS_UPD_IR : TS_SH_IR;
            TS_UPD_IR: tap_d.st = tms ? TS_SEL_DR : TS_IDLE;
            default:   tap_d.st = TS_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tap_q <= '{st: TS_RESET};
        end else begin
            tap_q <= tap_d;
        end
    end

    assign state_o = tap_q.st;

    AST_TLR_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
        (state_o == TS_RESET) && tms |=> (state_o == TS_RESET));  // R1

    AST_UPD_TO_IDLE: assert property (@(posedge tck) disable iff (!trst_n)
        ((state_o == TS_UPD_DR) || (state_o == TS_UPD_IR)) && !tms |=> (state_o == TS_IDLE));  // R1

endmodule

// File: rtl/dbg_dmi_bridge.sv
module dbg_dmi_bridge
    import dbg_jtag_pkg::*;
#(
    parameter int ABITS = 7,
    localparam int AW   = ABITS + 34
)(
    input  logic             tck,
    input  logic             trst_n,
    input  logic             upd_access_i,
    input  logic [AW-1:0]    word_i,
    input  logic             clr_i,
    output logic             req_o,
    output logic             we_o,
    output logic [ABITS-1:0] addr_o,
    output logic [31:0]      wdata_o,
    input  logic [31:0]      rdata_i,
    input  logic             ok_i,
    output logic [AW-1:0]    resp_o,
    output logic [1:0]       status_o
);

    typedef struct packed {
        logic [ABITS-1:0] addr;
        logic [31:0]      data;
        logic [1:0]       st;
    } resp_t;

    resp_t rsp_d, rsp_q;
    logic [1:0] op;

    assign op      = word_i[1:0];
    assign req_o   = upd_access_i && ((op == OP_RD) || (op == OP_WR));
    assign we_o    = req_o && (op == OP_WR);
    assign addr_o  = word_i[AW-1:34];
    assign wdata_o = word_i[33:2];

    always_comb begin
        rsp_d = rsp_q;
        if (clr_i) begin
            rsp_d = '0;
        end else if (req_o) begin
            rsp_d.addr = addr_o;
            if (ok_i) begin
                rsp_d.st = ST_OK;
                if (!we_o) begin
                    rsp_d.data = rdata_i;
                end
            end else begin
                rsp_d.st = ST_FAIL;
            end
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign resp_o   = rsp_q;
    assign status_o = rsp_q.st;

    AST_REQ_SINGLE: assert property (@(posedge tck) disable iff (!trst_n)
        req_o |=> !req_o);  // R8

    AST_READ_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
        req_o && !we_o && ok_i |=> (resp_o[33:2] == $past(rdata_i)) && (status_o == ST_OK));  // R8

    AST_FAIL_CODE: assert property (@(posedge tck) disable iff (!trst_n)
        req_o && !ok_i && !clr_i |=> (status_o == ST_FAIL));  // R10

    AST_IDLE_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
        !req_o && !clr_i |=> $stable(resp_o));  // R11

    AST_CLEAR_OK: assert property (@(posedge tck) disable iff (!trst_n)
        clr_i |=> (resp_o == '0));  // R12

endmodule

// File: rtl/dbg_jtag_xport.sv
module dbg_jtag_xport
    import dbg_jtag_pkg::*;
#(
    parameter int          ABITS      = 7,
    parameter logic [31:0] IDCODE_VAL = 32'h1DEB_0001,
    parameter logic [2:0]  IDLE_HINT  = 3'd1
)(
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             dbus_req,
    output logic             dbus_we,
    output logic [ABITS-1:0] dbus_addr,
    output logic [31:0]      dbus_wdata,
    input  logic [31:0]      dbus_rdata,
    input  logic             dbus_ok
);

    localparam int AW = ABITS + 34;
    localparam int PW = $clog2(AW);

    typedef struct packed {
        logic [IR_W-1:0] ir;
        logic [IR_W-1:0] irsr;
        logic [AW-1:0]   drsr;
    } scan_regs_t;

    scan_regs_t scn_d, scn_q;
    tap_state_e state;
    logic [AW-1:0] resp_word;
    logic [1:0]    resp_st;
    logic [31:0]   ctrl_word;
    logic [AW-1:0] cap_val;
    logic [PW-1:0] msb_idx;
    logic          upd_access;
    logic          ctrl_clr;
    logic          shifting;

    dbg_tap_ctrl u_tap (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_o (state)
    );

    assign ctrl_word = {15'd0, 1'b0, 1'b0, IDLE_HINT, resp_st, 6'(ABITS), 4'd1};

    always_comb begin
        case (scn_q.ir)
            IRC_IDCODE: begin
                cap_val = {{(AW-32){1'b0}}, IDCODE_VAL};
                msb_idx = PW'(31);
            end
            IRC_CTRL: begin
                cap_val = {{(AW-32){1'b0}}, ctrl_word};
                msb_idx = PW'(31);
            end
            IRC_ACCESS: begin
                cap_val = resp_word;
                msb_idx = PW'(AW-1);
            end
            default: begin
                cap_val = '0;
                msb_idx = '0;
            end
        endcase
    end

    always_comb begin
        scn_d = scn_q;
        case (state)
            TS_RESET:  scn_d.ir   = IRC_IDCODE;
            TS_CAP_IR: scn_d.irsr = IR_CAPTURE;
            TS_SH_IR:  scn_d.irsr = {tdi, scn_q.irsr[IR_W-1:1]};
            TS_UPD_IR: scn_d.ir   = scn_q.irsr;
            TS_CAP_DR: scn_d.drsr = cap_val;
            TS_SH_DR: begin
                scn_d.drsr          = {1'b0, scn_q.drsr[AW-1:1]};
                scn_d.drsr[msb_idx] = tdi;
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            scn_q <= '{ir: IRC_IDCODE, irsr: '0, drsr: '0};
        end else begin
            scn_q <= scn_d;
        end
    end

    assign shifting = (state == TS_SH_IR) || (state == TS_SH_DR);

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo <= 1'b0;
        end else if (state == TS_SH_IR) begin
            tdo <= scn_q.irsr[0];
        end else if (state == TS_SH_DR) begin
            tdo <= scn_q.drsr[0];
        end else begin
            tdo <= 1'b0;
        end
    end

    assign upd_access = (state == TS_UPD_DR) && (scn_q.ir == IRC_ACCESS);
    assign ctrl_clr   = (state == TS_UPD_DR) && (scn_q.ir == IRC_CTRL) && scn_q.drsr[CTRL_CLR_BIT];

    dbg_dmi_bridge #(
        .ABITS (ABITS)
    ) u_bridge (
        .tck          (tck),
        .trst_n       (trst_n),
        .upd_access_i (upd_access),
        .word_i       (scn_q.drsr),
        .clr_i        (ctrl_clr),
        .req_o        (dbus_req),
        .we_o         (dbus_we),
        .addr_o       (dbus_addr),
        .wdata_o      (dbus_wdata),
        .rdata_i      (dbus_rdata),
        .ok_i         (dbus_ok),
        .resp_o       (resp_word),
        .status_o     (resp_st)
    );

    AST_TDO_QUIET: assert property (@(posedge tck) disable iff (!trst_n)
        !shifting |-> (tdo == 1'b0));  // R3

    AST_REQ_IN_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
        dbus_req |-> (state == TS_UPD_DR) && (scn_q.ir == IRC_ACCESS));  // R8

    AST_CAPIR_PATTERN: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TS_CAP_IR) |=> (scn_q.irsr == IR_CAPTURE));  // R2

endmodule

// File: tb/dbg_jtag_xport_tb.sv
`timescale 1ns/100ps
module dbg_jtag_xport_tb;

    localparam int          ABITS = 7;
    localparam int          AW    = ABITS + 34;
    localparam logic [31:0] IDV   = 32'h1DEB_0001;
    localparam logic [2:0]  IDLE  = 3'd1;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic tdo;
    logic dbus_req, dbus_we, dbus_ok;
    logic [ABITS-1:0] dbus_addr;
    logic [31:0] dbus_wdata, dbus_rdata;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    typedef struct {
        logic             we;
        logic [ABITS-1:0] addr;
        logic [31:0]      wdata;
    } exp_req_t;
    exp_req_t exp_q[$];

    logic [31:0] mem     [0:(1<<ABITS)-1];
    logic [31:0] ref_mem [0:(1<<ABITS)-1];

    logic [ABITS-1:0] m_addr = '0;
    logic [31:0]      m_data = '0;
    logic [1:0]       m_st   = 2'd0;

    always #2 tck = ~tck;

    dbg_jtag_xport #(.ABITS(ABITS), .IDCODE_VAL(IDV), .IDLE_HINT(IDLE)) u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .dbus_req(dbus_req), .dbus_we(dbus_we), .dbus_addr(dbus_addr),
        .dbus_wdata(dbus_wdata), .dbus_rdata(dbus_rdata), .dbus_ok(dbus_ok)
    );

    // addresses at 0x40 and above are refused
    assign dbus_ok    = (dbus_addr < 7'h40);
    assign dbus_rdata = mem[dbus_addr];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected requests, models the register port
    always @(negedge tck) begin
        if (trst_n && dbus_req) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R11 unexpected request actual=%h expected=none", {dbus_we, dbus_addr});
            end else begin
                exp_req_t e;
                e = exp_q.pop_front();
                if (dbus_we !== e.we || dbus_addr !== e.addr || (e.we && dbus_wdata !== e.wdata)) begin
                    bad++;
                    $display("FAIL R8/R9 request actual=%h expected=%h",
                             {dbus_we, dbus_addr, dbus_wdata}, {e.we, e.addr, e.wdata});
                end
            end
            if (dbus_we && dbus_ok) mem[dbus_addr] = dbus_wdata;
        end
    end

    always @(posedge tck) begin
        cycles++;
        if (cycles > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick(input logic m, input logic d, output logic o);
        tms = m;
        tdi = d;
        #1;
        o = tdo;
        @(posedge tck);
        @(negedge tck);
        #0.5;
    endtask

    task automatic scan_ir(input logic [4:0] v, output logic [4:0] o);
        logic b;
        tick(1'b1, 1'b0, b);
        tick(1'b1, 1'b0, b);
        tick(1'b0, 1'b0, b);
        tick(1'b0, 1'b0, b);
        for (int i = 0; i < 5; i++) begin
            tick(i == 4, v[i], b);
            o[i] = b;
        end
        tick(1'b1, 1'b0, b);
        tick(1'b0, 1'b0, b);
    endtask

    task automatic scan_dr(input logic [AW-1:0] v, input int n, output logic [AW-1:0] o);
        logic b;
        o = '0;
        tick(1'b1, 1'b0, b);
        tick(1'b0, 1'b0, b);
        tick(1'b0, 1'b0, b);
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, v[i], b);
            o[i] = b;
        end
        tick(1'b1, 1'b0, b);
        tick(1'b0, 1'b0, b);
    endtask

    // driver: scans one bus-access word, checks the previous response, pushes the request
    task automatic access(input string req, input logic [1:0] op,
                          input logic [ABITS-1:0] a, input logic [31:0] d);
        logic [AW-1:0] o;
        exp_req_t e;
        if (op == 2'd1 || op == 2'd2) begin
            e.we = (op == 2'd2);
            e.addr = a;
            e.wdata = d;
            exp_q.push_back(e);
        end
        scan_dr({a, d, op}, AW, o);
        check(req, 64'(o), 64'({m_addr, m_data, m_st}));
        if (op == 2'd1 || op == 2'd2) begin
            m_addr = a;
            if (a < 7'h40) begin
                m_st = 2'd0;
                if (op == 2'd1) m_data = ref_mem[a];
                else ref_mem[a] = d;
            end else begin
                m_st = 2'd2;
            end
        end
    endtask

    function automatic logic [31:0] ctrl_exp(input logic [1:0] st);
        return (32'(IDLE) << 12) | (32'(st) << 10) | (32'(ABITS) << 4) | 32'd1;
    endfunction

    initial begin
        logic [4:0] ir_o;
        logic [AW-1:0] o;
        logic b;
        for (int i = 0; i < (1 << ABITS); i++) begin
            mem[i] = 32'hA5A5_0000 ^ (i * 32'h0101_0101);
            ref_mem[i] = mem[i];
        end
        #9.5;
        // R13: reset state at the ports
        check("R13 tdo after reset", 64'(tdo), 64'd0);
        check("R13 dbus_req after reset", 64'(dbus_req), 64'd0);
        trst_n = 1'b1;
        @(negedge tck);
        #0.5;
        tick(1'b0, 1'b0, b);
        // R4 / R2: IDCODE selected by reset
        scan_dr('0, 32, o);
        check("R4 idcode after reset", 64'(o[31:0]), 64'(IDV));
        // R2: capture-IR pattern
        scan_ir(5'h11, ir_o);
        check("R2 capture-IR pattern", 64'(ir_o), 64'h01);
        // R13, R7: first access scan sees cleared response
        access("R13 R7 reset response", 2'd0, 7'h12, 32'hFFFF_FFFF);
        // R9 write, R8 read back
        access("R11 nop leaves response", 2'd2, 7'h05, 32'hCAFE_F00D);
        access("R9 write status", 2'd1, 7'h05, 32'h0);
        access("R8 read data", 2'd1, 7'h3F, 32'h0);
        access("R8 read second address", 2'd0, 7'h00, 32'h0);
        // R10: refused write then refused read
        access("R10 pre-fail", 2'd2, 7'h50, 32'h1234_5678);
        access("R10 write refused", 2'd1, 7'h60, 32'h0);
        // R11: reserved op
        access("R10 read refused", 2'd3, 7'h01, 32'hDEAD_BEEF);
        access("R11 reserved op no effect", 2'd0, 7'h02, 32'h0);
        check("R8 R9 all requests seen", 64'(exp_q.size()), 64'd0);
        // R6: control word shows failure status
        scan_ir(5'h10, ir_o);
        scan_dr('0, 32, o);
        check("R6 control word", 64'(o[31:0]), 64'(ctrl_exp(2'd2)));
        // R12: clear via bit 16
        scan_dr(AW'(32'h0001_0000), 32, o);
        scan_dr('0, 32, o);
        check("R12 control status cleared", 64'(o[31:0]), 64'(ctrl_exp(2'd0)));
        scan_ir(5'h11, ir_o);
        m_addr = '0; m_data = '0; m_st = 2'd0;
        access("R12 response cleared", 2'd0, 7'h00, 32'h0);
        // R5: bypass and an unlisted code
        scan_ir(5'h1F, ir_o);
        scan_dr(AW'(8'hB6), 8, o);
        check("R5 bypass delay", 64'(o[7:0]), 64'({8'hB6} << 1) & 64'hFF);
        scan_ir(5'h05, ir_o);
        scan_dr(AW'(8'h5B), 8, o);
        check("R5 unlisted code as bypass", 64'(o[7:0]), 64'({8'h5B} << 1) & 64'hFF);
        // R3: idle TDO
        check("R3 tdo quiet in idle", 64'(tdo), 64'd0);
        // R1: five TMS-high cycles reset the TAP and select IDCODE
        scan_ir(5'h11, ir_o);
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, b);
        tick(1'b0, 1'b0, b);
        scan_dr('0, 32, o);
        check("R1 TMS reset to IDCODE", 64'(o[31:0]), 64'(IDV));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule